// File: doc/BRIEF.md
# I2C SDA Driver with Delay, Arbitration and Clock Wait

This block sits between a serial shifter and the open-drain I2C pins. On every SCL falling edge it takes the next transmit bit and presents it on SDA. It can present the bit at once, or after a programmable number of ticks from an external divider, which gives the data line hold time after SCL falls. The pins are driven only through drive-low enables. A logic 1 releases the line and a logic 0 pulls it down.

On each SCL rising edge the block compares the level it intends with the level sampled on the bus. If it released SDA but the bus reads low, another master has won. The block then sets a sticky arbitration-lost flag and sends a one-cycle bus-collision pulse to the interrupt logic. It also lets go of SDA until the next byte begins.

A separate clock-wait feature counts SCL falling edges from the start of a byte. When software has enabled the wait, the ninth falling edge holds SCL low, and SCL stays held until software withdraws the enable. Byte shifting and baud generation are done elsewhere.

Top module: `i2c_sda_drv`

## Requirements
- R1: After reset `sda_oe_o`, `scl_oe_o`, `arb_lost_o` and `bus_col_o` are all 0, so both lines are released.
- R2: `sda_oe_o` = 1 pulls SDA low. A presented data bit of 0 drives low and a presented bit of 1 releases the line.
- R3: When `dly_en_i` = 0 or `dly_code_i` = 0, the `tx_bit_i` sampled in a cycle with `scl_fall_i` = 1 is presented on SDA in the next cycle.
- R4: When `dly_en_i` = 1 and `dly_code_i` = N (N > 0), the `tx_bit_i` sampled at the falling edge is presented one cycle after the N-th `div_tick_i` that arrives strictly after the fall cycle. Until then the previously presented level stays.
- R5: In a cycle with `scl_rise_i` = 1, if the presented level is 1, the block is not already in lost hold, and `sda_in_i` = 0, then `arb_lost_o` goes to 1 and `bus_col_o` pulses high for exactly one cycle, both in the next cycle.
- R6: `arb_lost_o` stays set until a cycle with `arb_clr_i` = 1. If a new detection occurs in that same cycle, the flag remains set.
- R7: After arbitration is lost, `sda_oe_o` stays 0 whatever data is presented, until a cycle with `byte_start_i` = 1.
- R8: When `cwait_en_i` = 1 at the ninth `scl_fall_i` after `byte_start_i`, `scl_oe_o` is 1 from the next cycle. It stays 1 while `cwait_en_i` = 1 and returns to 0 in the cycle after `cwait_en_i` is seen 0.
- R9: Falling edges other than the ninth never set `scl_oe_o`. A ninth edge that arrives with `cwait_en_i` = 0 does not set it either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_bit_i | input | 1 | Next data bit from the shifter |
| scl_fall_i | input | 1 | One-cycle pulse on SCL falling edge |
| scl_rise_i | input | 1 | One-cycle pulse on SCL rising edge |
| sda_in_i | input | 1 | Synchronised SDA bus level |
| dly_en_i | input | 1 | Enables the SDA output delay |
| dly_code_i | input | 3 | Delay length in divider ticks |
| div_tick_i | input | 1 | Divided-clock tick used to count the delay |
| byte_start_i | input | 1 | Marks the start of a byte; restarts the bit count and ends lost hold |
| cwait_en_i | input | 1 | Clock-wait enable, cleared by software to release SCL |
| arb_clr_i | input | 1 | Clears the arbitration-lost flag |
| sda_oe_o | output | 1 | SDA drive-low enable |
| scl_oe_o | output | 1 | SCL drive-low enable (clock wait) |
| arb_lost_o | output | 1 | Sticky arbitration-lost flag |
| bus_col_o | output | 1 | One-cycle bus-collision event |

## Verification
The properties assume that edge inputs are single-cycle pulses. They also assume that rising and falling edges never share a cycle and that `byte_start_i` never coincides with a falling edge. The stimulus follows these rules by building every SCL edge and byte boundary with separate tasks that raise one pulse at a time. Between falling edges, the bench leaves enough divider ticks for any pending delay to expire before the next fall. It forces a collision only where the data bit is 1 and no lost hold is already active.

// File: rtl/i2c_sda_pkg.sv
package i2c_sda_pkg;
  localparam int unsigned DLY_W       = 3;
  localparam int unsigned FRAME_BITS  = 9;
  localparam int unsigned BCNT_W      = $clog2(FRAME_BITS + 1);
  typedef logic [DLY_W-1:0] dly_code_t;
endpackage

// File: rtl/i2c_sda_dly.sv
module i2c_sda_dly #(
  parameter int unsigned DLY_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_fall_i,
  input  logic             tx_bit_i,
  input  logic             dly_en_i,
  input  logic [DLY_W-1:0] dly_code_i,
  input  logic             div_tick_i,
  output logic             lvl_o
);
  logic             pend_q;
  logic             bit_q;
  logic [DLY_W-1:0] cnt_q;
  logic             bypass;

  assign bypass = !dly_en_i || (dly_code_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_o  <= 1'b1;
      pend_q <= 1'b0;
      bit_q  <= 1'b1;
      cnt_q  <= '0;
    end else if (scl_fall_i) begin
      if (bypass) begin
        lvl_o  <= tx_bit_i;
        pend_q <= 1'b0;
      end else begin
        pend_q <= 1'b1;
        bit_q  <= tx_bit_i;
        cnt_q  <= dly_code_i;
      end
    end else if (pend_q && div_tick_i) begin
      if (cnt_q == DLY_W'(1)) begin
        lvl_o  <= bit_q;
        pend_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_sda_arb.sv
module i2c_sda_arb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_rise_i,
  input  logic sda_in_i,
  input  logic lvl_i,
  input  logic byte_start_i,
  input  logic arb_clr_i,
  output logic lost_o,
  output logic col_o,
  output logic hold_o
);
  logic det;

  // only a released line can lose; a held-off line is not re-checked
  assign det = scl_rise_i && lvl_i && !hold_o && !sda_in_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lost_o <= 1'b0;
      col_o  <= 1'b0;
      hold_o <= 1'b0;
    end else begin
      col_o  <= det;
      lost_o <= det || (lost_o && !arb_clr_i);
      hold_o <= det || (hold_o && !byte_start_i);
    end
  end
endmodule

// File: rtl/i2c_scl_wait.sv
module i2c_scl_wait #(
  parameter int unsigned FRAME_BITS = 9,
  parameter int unsigned BCNT_W     = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_fall_i,
  input  logic byte_start_i,
  input  logic cwait_en_i,
  output logic hold_o
);
  localparam logic [BCNT_W-1:0] LAST = BCNT_W'(FRAME_BITS);
  localparam logic [BCNT_W-1:0] PREV = BCNT_W'(FRAME_BITS - 1);

  logic [BCNT_W-1:0] cnt_q;
  logic              last_fall;

  assign last_fall = scl_fall_i && !byte_start_i && (cnt_q == PREV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hold_o <= 1'b0;
    end else begin
      if (byte_start_i)                    cnt_q <= '0;
      else if (scl_fall_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
      hold_o <= cwait_en_i && (hold_o || last_fall);
    end
  end
endmodule

// File: rtl/i2c_sda_drv.sv
module i2c_sda_drv
  import i2c_sda_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tx_bit_i,
  input  logic            scl_fall_i,
  input  logic            scl_rise_i,
  input  logic            sda_in_i,
  input  logic            dly_en_i,
  input  logic [DLY_W-1:0] dly_code_i,
  input  logic            div_tick_i,
  input  logic            byte_start_i,
  input  logic            cwait_en_i,
  input  logic            arb_clr_i,
  output logic            sda_oe_o,
  output logic            scl_oe_o,
  output logic            arb_lost_o,
  output logic            bus_col_o
);
  logic sda_lvl;
  logic lost_hold;

  i2c_sda_dly #(.DLY_W(DLY_W)) u_dly (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_fall_i (scl_fall_i),
    .tx_bit_i   (tx_bit_i),
    .dly_en_i   (dly_en_i),
    .dly_code_i (dly_code_i),
    .div_tick_i (div_tick_i),
    .lvl_o      (sda_lvl)
  );

  i2c_sda_arb u_arb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .scl_rise_i   (scl_rise_i),
    .sda_in_i     (sda_in_i),
    .lvl_i        (sda_lvl),
    .byte_start_i (byte_start_i),
    .arb_clr_i    (arb_clr_i),
    .lost_o       (arb_lost_o),
    .col_o        (bus_col_o),
    .hold_o       (lost_hold)
  );

  i2c_scl_wait #(.FRAME_BITS(FRAME_BITS), .BCNT_W(BCNT_W)) u_wait (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .scl_fall_i   (scl_fall_i),
    .byte_start_i (byte_start_i),
    .cwait_en_i   (cwait_en_i),
    .hold_o       (scl_oe_o)
  );

  assign sda_oe_o = !sda_lvl && !lost_hold;
endmodule

// File: rtl/i2c_sda_drv_chk.sv
module i2c_sda_drv_chk
  import i2c_sda_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_bit_i,
  input logic             scl_fall_i,
  input logic             dly_en_i,
  input logic [DLY_W-1:0] dly_code_i,
  input logic             cwait_en_i,
  input logic             arb_clr_i,
  input logic             sda_oe_o,
  input logic             scl_oe_o,
  input logic             arb_lost_o,
  input logic             bus_col_o,
  input logic             sda_lvl,
  input logic             lost_hold
);
  assert_bypass_next_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_fall_i && (!dly_en_i || dly_code_i == '0)) |=> (sda_lvl == $past(tx_bit_i)));

  assert_delay_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_fall_i && dly_en_i && dly_code_i != '0) |=> $stable(sda_lvl));

  assert_col_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_col_o |=> !bus_col_o);

  assert_col_sets_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_col_o |-> arb_lost_o);

  assert_flag_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_lost_o && !arb_clr_i) |=> arb_lost_o);

  assert_lost_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_hold |-> !sda_oe_o);

  assert_wait_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_oe_o && cwait_en_i) |=> scl_oe_o);

  assert_wait_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cwait_en_i |=> !scl_oe_o);
endmodule

bind i2c_sda_drv i2c_sda_drv_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_bit_i   (tx_bit_i),
  .scl_fall_i (scl_fall_i),
  .dly_en_i   (dly_en_i),
  .dly_code_i (dly_code_i),
  .cwait_en_i (cwait_en_i),
  .arb_clr_i  (arb_clr_i),
  .sda_oe_o   (sda_oe_o),
  .scl_oe_o   (scl_oe_o),
  .arb_lost_o (arb_lost_o),
  .bus_col_o  (bus_col_o),
  .sda_lvl    (sda_lvl),
  .lost_hold  (lost_hold)
);

// File: tb/i2c_sda_drv_tb.sv
module i2c_sda_drv_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_bit = 1'b1, scl_fall = 1'b0, scl_rise = 1'b0, sda_in = 1'b1;
  logic       dly_en = 1'b0, div_tick = 1'b0, byte_start = 1'b0;
  logic       cwait_en = 1'b0, arb_clr = 1'b0;
  logic [2:0] dly_code = 3'd0;
  logic       sda_oe, scl_oe, arb_lost, bus_col;

  int    vectors = 0, fails = 0;
  int    tick_per = 0, tcnt = 0;
  string cur_req = "R1";

  // reference state
  int m_lvl = 1, m_bit = 1, m_left = 0, m_col = 0, m_lost = 0, m_lh = 0;
  int m_bits = 0, m_hold = 0;

  always #4 clk = ~clk;

  i2c_sda_drv u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_bit_i(tx_bit), .scl_fall_i(scl_fall),
    .scl_rise_i(scl_rise), .sda_in_i(sda_in), .dly_en_i(dly_en),
    .dly_code_i(dly_code), .div_tick_i(div_tick), .byte_start_i(byte_start),
    .cwait_en_i(cwait_en), .arb_clr_i(arb_clr), .sda_oe_o(sda_oe),
    .scl_oe_o(scl_oe), .arb_lost_o(arb_lost), .bus_col_o(bus_col)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lvl = 1; m_bit = 1; m_left = 0; m_col = 0; m_lost = 0; m_lh = 0;
      m_bits = 0; m_hold = 0;
    end else begin
      automatic int det = (scl_rise && m_lvl == 1 && m_lh == 0 && !sda_in) ? 1 : 0;
      automatic int ninth = (scl_fall && !byte_start && m_bits == 8) ? 1 : 0;
      m_col  = det;
      m_lost = (det != 0 || (m_lost != 0 && !arb_clr)) ? 1 : 0;
      m_lh   = (det != 0 || (m_lh != 0 && !byte_start)) ? 1 : 0;
      if (scl_fall) begin
        if (!dly_en || dly_code == 0) begin m_lvl = tx_bit; m_left = 0; end
        else begin m_left = dly_code; m_bit = tx_bit; end
      end else if (m_left > 0 && div_tick) begin
        m_left--;
        if (m_left == 0) m_lvl = m_bit;
      end
      m_hold = (cwait_en && (m_hold != 0 || ninth != 0)) ? 1 : 0;
      if (byte_start) m_bits = 0;
      else if (scl_fall && m_bits < 9) m_bits++;
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("sda_oe", sda_oe, (m_lvl == 0 && m_lh == 0) ? 1 : 0);
    chk("scl_oe", scl_oe, m_hold);
    chk("arb_lost", arb_lost, m_lost);
    chk("bus_col", bus_col, m_col);
  endtask

  task automatic cyc();
    div_tick = (tick_per != 0) && ((tcnt % tick_per) == tick_per - 1);
    tcnt++;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic fall(input logic b);
    tx_bit = b; scl_fall = 1'b1; cyc(); scl_fall = 1'b0;
  endtask

  task automatic rise(input logic bus);
    sda_in = bus; scl_rise = 1'b1; cyc(); scl_rise = 1'b0; sda_in = 1'b1;
  endtask

  task automatic bstart();
    byte_start = 1'b1; cyc(); byte_start = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    // R1: reset values
    #20;
    @(negedge clk);
    cur_req = "R1";
    chk("sda_oe", sda_oe, 0); chk("scl_oe", scl_oe, 0);
    chk("arb_lost", arb_lost, 0); chk("bus_col", bus_col, 0);
    rst_n = 1'b1;
    idle(3);

    // R2/R3: delay disabled
    cur_req = "R3";
    dly_en = 1'b0; dly_code = 3'd5;
    fall(1'b0); idle(2);
    cur_req = "R2"; chk("sda_oe low drive", sda_oe, 1);
    cur_req = "R3";
    fall(1'b1); idle(2); fall(1'b0); fall(1'b1); idle(2);
    // R3: enabled but code 0
    dly_en = 1'b1; dly_code = 3'd0;
    fall(1'b0); idle(1); fall(1'b1); idle(2);

    // R4: delayed output, various codes and tick rates
    cur_req = "R4";
    tick_per = 4; tcnt = 0;
    dly_code = 3'd3; fall(1'b0); idle(16); fall(1'b1); idle(16);
    dly_code = 3'd7; fall(1'b0); idle(6);
    chk("sda_oe before expiry", sda_oe, 0);
    idle(30);
    chk("sda_oe after expiry", sda_oe, 1);
    tick_per = 1;
    dly_code = 3'd1; fall(1'b1); idle(3); fall(1'b0); idle(3);
    dly_code = 3'd2; tick_per = 3; fall(1'b1); idle(10);
    tick_per = 0; dly_en = 1'b0;

    // R5/R6/R7: arbitration loss
    cur_req = "R5";
    bstart();
    fall(1'b1); idle(1); rise(1'b1); idle(1);
    chk("no loss on match", arb_lost, 0);
    fall(1'b1); idle(1); rise(1'b0); idle(2);
    chk("arb_lost set", arb_lost, 1);
    cur_req = "R7";
    fall(1'b0); idle(2);
    chk("released after loss", sda_oe, 0);
    rise(1'b0); fall(1'b1); idle(1);
    cur_req = "R6";
    idle(4);
    arb_clr = 1'b1; cyc(); arb_clr = 1'b0; idle(1);
    chk("arb_lost cleared", arb_lost, 0);
    cur_req = "R7";
    bstart(); fall(1'b0); idle(2);
    chk("drives again", sda_oe, 1);
    // R6: detection and clear in same cycle
    cur_req = "R6";
    fall(1'b1); idle(1);
    arb_clr = 1'b1; rise(1'b0); arb_clr = 1'b0; idle(2);
    chk("set wins over clear", arb_lost, 1);
    arb_clr = 1'b1; cyc(); arb_clr = 1'b0;
    bstart(); idle(1);

    // R8: clock wait on ninth fall
    cur_req = "R8";
    cwait_en = 1'b1;
    bstart();
    for (int i = 0; i < 8; i++) begin fall(1'b1); idle(1); rise(1'b1); end
    chk("no hold before ninth", scl_oe, 0);
    fall(1'b1); idle(5);
    chk("hold after ninth", scl_oe, 1);
    cwait_en = 1'b0; idle(2);
    chk("hold released", scl_oe, 0);

    // R9: ninth fall with wait disabled, extra falls afterwards
    cur_req = "R9";
    bstart();
    for (int i = 0; i < 9; i++) begin fall(1'b0); idle(1); end
    cwait_en = 1'b1; idle(2);
    for (int i = 0; i < 3; i++) begin fall(1'b1); idle(1); end
    chk("no hold on late edges", scl_oe, 0);
    cwait_en = 1'b0; idle(3);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule